// File: doc/BRIEF.md
# Endian-Selectable Aligned Load/Store Unit

This block sits between a load/store pipeline and a byte-addressable data store that is built from 8-byte rows. Each request carries a byte address, an access size (byte, half word, word or double word), a read/write flag, a sign-extension flag and store data. A run-time mode input picks the byte order. The address splits into two parts. The three low bits choose a starting byte lane inside a row. The bits above them choose the row.

For a store, the unit moves the operand bytes into the addressed lanes and writes only those lanes. For a load, it collects the addressed bytes and orders them for the selected mode. It then widens the result to 64 bits with zeros or with copies of the sign bit. A request that breaks the natural alignment rule for its size is answered with an error and never touches the array. The row array is inside the block. One request can be accepted on every cycle. Each accepted request gets exactly one response, one cycle later.

A small state machine holds the kind of response that is presented on the current cycle. ST_WAKE is entered on reset; there the unit is not ready and the only transition is to ST_IDLE. From ST_IDLE, ST_LOAD_RSP, ST_STORE_ACK and ST_ERR_RSP the next state depends on the request accepted on that edge:
- A misaligned request goes to ST_ERR_RSP.
- An aligned store goes to ST_STORE_ACK.
- An aligned load goes to ST_LOAD_RSP.
- No request goes to ST_IDLE.

Top module: `endian_mem_unit`

## Requirements
- R1: `req_ready` is 0 while reset is active and during the first cycle after reset is released. From then on it is 1, and a request is accepted on every rising edge where `req_valid` and `req_ready` are both 1.
- R2: Every accepted request produces `rsp_valid` = 1 on the cycle that follows its acceptance edge, and on no other cycle. A cycle without an accepted request is followed by `rsp_valid` = 0.
- R3: Size codes are 2'b00 byte, 2'b01 half word, 2'b10 word and 2'b11 double word. An access is misaligned when the address is not a multiple of the access size in bytes. Byte accesses are never misaligned. A misaligned request is answered with `rsp_valid` = 1, `rsp_err` = 1 and `rsp_rdata` = 0.
- R4: A misaligned store leaves every byte of the array unchanged.
- R5: An aligned store changes exactly the bytes from the address up to the address plus the size minus one. All other bytes of the row keep their values.
- R6: With `endian_mode` = 0 (big-endian), the byte at the lowest address of an access is the most significant byte of the operand, for both stores and loads.
- R7: With `endian_mode` = 1 (little-endian), the byte at the lowest address of an access is the least significant byte of the operand, for both stores and loads.
- R8: A big-endian word store of 0x10203040 to address 4, followed by a little-endian word load from address 4, returns 0x40302010.
- R9: A load with `req_signed` = 0 returns the loaded bytes in the low bits of `rsp_rdata`, with all higher bits 0.
- R10: A load with `req_signed` = 1 copies the most significant loaded bit into every higher bit of `rsp_rdata`.
- R11: The load result appears on `rsp_rdata` one cycle after acceptance. A load accepted on the cycle right after a store to the same bytes returns the stored data.
- R12: An aligned store is answered with `rsp_valid` = 1, `rsp_err` = 0 and `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| endian_mode | input | 1 | 0 = big-endian, 1 = little-endian, sampled with the request |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The unit can accept a request |
| req_addr | input | 11 | Byte address: [2:0] is the lane, [10:3] is the row |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | 1 = store, 0 = load |
| req_signed | input | 1 | 1 = sign-extend loads, 0 = zero-extend loads |
| req_wdata | input | 64 | Store operand, right-aligned |
| rsp_valid | output | 1 | A response is presented |
| rsp_err | output | 1 | The response reports a misaligned request |
| rsp_rdata | output | 64 | Load result, 0 for store and error responses |

## Verification
Because requests are accepted on every cycle, the response to one request is always on the ports while the next request is being accepted. The case that matters is a load response being driven on the same cycle as a store to the same row is written, or a store write followed at once by a load of the same bytes. The bench provokes both back to back. For each size, lane offset, mode and extension flag, it issues a store, then a load of the same address, then a full-row read in the opposite byte order. Every response is compared with a byte-level model of the array that the bench updates in program order, so that a stale read or a lost lane shows up as a data mismatch.

// File: rtl/mau_pkg.sv
`timescale 1ns/1ps
package mau_pkg;

    localparam int LANE_BYTES = 8;
    localparam int LANE_AW    = $clog2(LANE_BYTES);
    localparam int DATA_W     = LANE_BYTES * 8;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_DWORD = 2'b11
    } access_size_e;

    typedef enum logic [2:0] {
        ST_WAKE      = 3'd0,
        ST_IDLE      = 3'd1,
        ST_LOAD_RSP  = 3'd2,
        ST_STORE_ACK = 3'd3,
        ST_ERR_RSP   = 3'd4
    } unit_state_e;

    typedef struct packed {
        logic [LANE_AW-1:0] lane;
        access_size_e       size;
        logic               little;
        logic               sign_ext;
    } load_ctl_t;

    // Number of bytes touched by an access of the given size.
    function automatic logic [LANE_AW:0] size_bytes(access_size_e s);
        return (LANE_AW+1)'(1) << s;
    endfunction

endpackage

// File: rtl/mau_align_check.sv
`timescale 1ns/1ps
module mau_align_check
    import mau_pkg::*;
(
    input  logic [LANE_AW-1:0] lane,
    input  access_size_e       size,
    output logic               misaligned
);

    logic [LANE_AW:0] span;
    logic [LANE_AW:0] low_mask;

    // An address is aligned when it is a multiple of the access span.
    always_comb begin
        span       = size_bytes(size);
        low_mask   = span - (LANE_AW+1)'(1);
        misaligned = |(lane & low_mask[LANE_AW-1:0]);
    end

endmodule

// File: rtl/mau_store_steer.sv
`timescale 1ns/1ps
module mau_store_steer
    import mau_pkg::*;
(
    input  logic [LANE_AW-1:0]    lane,
    input  access_size_e          size,
    input  logic                  little,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     row_wdata,
    output logic [LANE_BYTES-1:0] byte_en
);

    logic [LANE_AW:0] span;
    assign span = size_bytes(size);

    // Each row lane works out which operand byte, if any, lands on it.
    for (genvar k = 0; k < LANE_BYTES; k++) begin : g_lane
        logic [LANE_AW:0]   rel;
        logic [LANE_AW:0]   src_full;
        logic [LANE_AW-1:0] src;
        logic               hit;
        logic [7:0]         lane_byte;

        always_comb begin
            rel       = (LANE_AW+1)'(k) - {1'b0, lane};
            src_full  = little ? rel : (span - (LANE_AW+1)'(1) - rel);
            src       = src_full[LANE_AW-1:0];
            hit       = (rel < span);
            lane_byte = hit ? wdata[{src, 3'b000} +: 8] : 8'h00;
        end

        assign byte_en[k]         = hit;
        assign row_wdata[8*k +: 8] = lane_byte;
    end

endmodule

// File: rtl/mau_load_extract.sv
`timescale 1ns/1ps
module mau_load_extract
    import mau_pkg::*;
(
    input  logic [DATA_W-1:0] row_rdata,
    input  load_ctl_t         ctl,
    output logic [DATA_W-1:0] data
);

    logic [LANE_AW:0]   span;
    logic [LANE_AW:0]   top_full;
    logic [LANE_AW-1:0] top_lane;
    logic [7:0]         fill;

    // Lane that holds the most significant byte of the operand.
    always_comb begin
        span     = size_bytes(ctl.size);
        top_full = ctl.little ? ({1'b0, ctl.lane} + span - (LANE_AW+1)'(1))
                              : {1'b0, ctl.lane};
        top_lane = top_full[LANE_AW-1:0];
        fill     = (ctl.sign_ext && row_rdata[{top_lane, 3'b111}]) ? 8'hFF : 8'h00;
    end

    for (genvar j = 0; j < LANE_BYTES; j++) begin : g_res
        logic [LANE_AW:0]   src_full;
        logic [LANE_AW-1:0] src;
        logic               used;
        logic [7:0]         res_byte;

        always_comb begin
            used     = ((LANE_AW+1)'(j) < span);
            src_full = ctl.little ? ({1'b0, ctl.lane} + (LANE_AW+1)'(j))
                                  : ({1'b0, ctl.lane} + span - (LANE_AW+1)'(1) - (LANE_AW+1)'(j));
            src      = src_full[LANE_AW-1:0];
            res_byte = used ? row_rdata[{src, 3'b000} +: 8] : fill;
        end

        assign data[8*j +: 8] = res_byte;
    end

endmodule

// File: rtl/mau_row_mem.sv
`timescale 1ns/1ps
module mau_row_mem
    import mau_pkg::*;
#(
    parameter  int ROWS   = 256,
    localparam int ROW_AW = $clog2(ROWS)
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic                  re,
    input  logic [ROW_AW-1:0]     row,
    input  logic [LANE_BYTES-1:0] byte_en,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata
);

    // One narrow array per byte lane, all addressed by the same row.
    for (genvar k = 0; k < LANE_BYTES; k++) begin : g_bank
        logic [7:0] cells [ROWS];
        logic [7:0] q;

        always_ff @(posedge clk) begin
            if (we && byte_en[k]) begin
                cells[row] <= wdata[8*k +: 8];
            end
            if (re) begin
                q <= cells[row];
            end
        end

        assign rdata[8*k +: 8] = q;
    end

endmodule

// File: rtl/endian_mem_unit.sv
`timescale 1ns/1ps
module endian_mem_unit
    import mau_pkg::*;
#(
    parameter  int ROWS   = 256,
    localparam int ROW_AW = $clog2(ROWS),
    localparam int ADDR_W = ROW_AW + LANE_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              endian_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic              req_signed,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);

    unit_state_e state_q, state_d;

    access_size_e          sz;
    logic [LANE_AW-1:0]    lane;
    logic [ROW_AW-1:0]     row;
    logic                  accept;
    logic                  misaligned;
    logic                  mem_we;
    logic                  mem_re;
    logic [DATA_W-1:0]     row_wdata;
    logic [LANE_BYTES-1:0] byte_en;
    logic [DATA_W-1:0]     row_rdata;
    logic [DATA_W-1:0]     load_data;
    load_ctl_t             ld_ctl_q;

    assign sz     = access_size_e'(req_size);
    assign lane   = req_addr[LANE_AW-1:0];
    assign row    = req_addr[ADDR_W-1:LANE_AW];
    assign accept = req_valid && req_ready;
    assign mem_we = accept && req_write && !misaligned;
    assign mem_re = accept && !req_write && !misaligned;

    mau_align_check u_align (
        .lane       (lane),
        .size       (sz),
        .misaligned (misaligned)
    );

    mau_store_steer u_steer (
        .lane      (lane),
        .size      (sz),
        .little    (endian_mode),
        .wdata     (req_wdata),
        .row_wdata (row_wdata),
        .byte_en   (byte_en)
    );

    mau_row_mem #(.ROWS(ROWS)) u_mem (
        .clk     (clk),
        .we      (mem_we),
        .re      (mem_re),
        .row     (row),
        .byte_en (byte_en),
        .wdata   (row_wdata),
        .rdata   (row_rdata)
    );

    mau_load_extract u_extract (
        .row_rdata (row_rdata),
        .ctl       (ld_ctl_q),
        .data      (load_data)
    );

    // Load attributes follow the read data by one cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_ctl_q <= '0;
        end else if (mem_re) begin
            ld_ctl_q <= '{lane: lane, size: sz, little: endian_mode, sign_ext: req_signed};
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAKE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: the kind of response owed for the request taken now.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_WAKE: state_d = ST_IDLE;
            ST_IDLE, ST_LOAD_RSP, ST_STORE_ACK, ST_ERR_RSP: begin
                if (!accept)         state_d = ST_IDLE;
                else if (misaligned) state_d = ST_ERR_RSP;
                else if (req_write)  state_d = ST_STORE_ACK;
                else                 state_d = ST_LOAD_RSP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state register.
    always_comb begin
        req_ready = 1'b1;
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            ST_WAKE:      req_ready = 1'b0;
            ST_IDLE:      ;
            ST_LOAD_RSP: begin
                rsp_valid = 1'b1;
                rsp_rdata = load_data;
            end
            ST_STORE_ACK: rsp_valid = 1'b1;
            ST_ERR_RSP: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default:      req_ready = 1'b0;
        endcase
    end

    assert_ready_returns_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);

    assert_resp_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);

    assert_resp_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(accept));

    assert_misalign_reported_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && misaligned) |=> (rsp_err && rsp_valid));

    assert_err_data_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0));

    assert_mask_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(byte_en) == int'(size_bytes(sz))));

    assert_zero_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD_RSP && !ld_ctl_q.sign_ext && ld_ctl_q.size != SZ_DWORD)
        |-> ((rsp_rdata >> (8 * int'(size_bytes(ld_ctl_q.size)))) == '0));

endmodule

// File: tb/endian_mem_unit_tb_top.sv
`timescale 1ns/1ps
module endian_mem_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        endian_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [10:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        req_signed = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [63:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] bm [0:2047];
    bit          pend = 1'b0;
    logic        exp_v, exp_e;
    logic [63:0] exp_d;
    string       exp_tag;

    always #10 clk = ~clk;

    endian_mem_unit dut_i (
        .clk(clk), .rst_n(rst_n), .endian_mode(endian_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_signed(req_signed),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata)
    );

    function automatic bit is_mis(input int a, input int sz);
        return (a % (1 << sz)) != 0;
    endfunction

    function automatic logic [63:0] model_load(input int a, input int sz, input bit md, input bit sg);
        int n = 1 << sz;
        logic [63:0] v = '0;
        for (int j = 0; j < n; j++)
            v[8*j +: 8] = md ? bm[a+j] : bm[a+n-1-j];
        if (sg && n < 8 && v[8*n-1])
            for (int j = n; j < 8; j++) v[8*j +: 8] = 8'hFF;
        return v;
    endfunction

    task automatic model_store(input int a, input int sz, input bit md, input logic [63:0] w);
        int n = 1 << sz;
        for (int i = 0; i < n; i++)
            bm[a+i] = md ? w[8*i +: 8] : w[8*(n-1-i) +: 8];
    endtask

    task automatic chk(input bit ok, input string tg, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tg, act, exp);
        end
    endtask

    task automatic check_resp();
        checks++;
        if (rsp_valid !== exp_v || rsp_err !== exp_e || rsp_rdata !== exp_d) begin
            fails++;
            $display("FAIL %s actual valid=%b err=%b data=%h expected valid=%b err=%b data=%h",
                     exp_tag, rsp_valid, rsp_err, rsp_rdata, exp_v, exp_e, exp_d);
        end
        pend = 1'b0;
    endtask

    // Checks the previous response and offers the next request on one falling edge.
    task automatic step(input bit v, input int a, input int sz, input bit wr,
                        input bit sg, input bit md, input logic [63:0] wd, input string tg);
        @(negedge clk);
        if (pend) check_resp();
        if (v) chk(req_ready === 1'b1, "R1 ready", {63'd0, req_ready}, 64'd1);
        req_valid   = v;
        req_addr    = 11'(a);
        req_size    = 2'(sz);
        req_write   = wr;
        req_signed  = sg;
        endian_mode = md;
        req_wdata   = wd;
        exp_tag     = tg;
        if (!v) begin
            exp_v = 1'b0; exp_e = 1'b0; exp_d = '0;
        end else if (is_mis(a, sz)) begin
            exp_v = 1'b1; exp_e = 1'b1; exp_d = '0;
        end else if (wr) begin
            exp_v = 1'b1; exp_e = 1'b0; exp_d = '0;
            model_store(a, sz, md, wd);
        end else begin
            exp_v = 1'b1; exp_e = 1'b0; exp_d = model_load(a, sz, md, sg);
        end
        pend = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b0, "R1 ready in reset", {63'd0, req_ready}, 64'd0);
        chk(rsp_valid === 1'b0, "R2 valid in reset", {63'd0, rsp_valid}, 64'd0);
        chk(rsp_err === 1'b0, "R3 err in reset", {63'd0, rsp_err}, 64'd0);
        rst_n = 1'b1;
        #5;
        chk(req_ready === 1'b0, "R1 ready after release", {63'd0, req_ready}, 64'd0);

        // Fill every row so that the model is fully known (R12 acks).
        for (int r = 0; r < 256; r++)
            step(1, r*8, 3, 1, 0, r[0], 64'h0123_4567_89AB_CDEF ^ {8{8'(r)}}, "R12 fill");

        // Mixed byte order on one word.
        step(1, 4, 2, 1, 0, 0, 64'h1020_3040, "R12");
        step(1, 4, 2, 0, 0, 1, '0, "R8");
        step(1, 4, 2, 0, 0, 0, '0, "R6");
        step(1, 0, 3, 0, 0, 1, '0, "R7 R5");

        // Sweep of mode, size, lane offset and extension flag.
        for (int md = 0; md < 2; md++)
            for (int sz = 0; sz < 4; sz++)
                for (int off = 0; off < 8; off++)
                    for (int sg = 0; sg < 2; sg++) begin
                        int it  = ((md*4 + sz)*8 + off)*2 + sg;
                        int row = 16 + it;
                        int a   = row*8 + off;
                        bit mis = is_mis(a, sz);
                        logic [63:0] wd = 64'h8192_A3B4_C5D6_E7F8 ^ {8{8'(it*29)}};
                        step(1, a, sz, 1, 0, md[0], wd, mis ? "R3 R4 store" : "R12 store");
                        step(1, a, sz, 0, sg[0], md[0], '0,
                             mis ? "R3 load" : (sg != 0 ? "R10 R11" : "R9 R11"));
                        step(1, row*8, 3, 0, 0, ~md[0], '0,
                             mis ? "R4 row" : (sz == 0 ? "R5 row" : (md != 0 ? "R6 row" : "R7 row")));
                    end

        step(0, 0, 0, 0, 0, 0, '0, "R2 idle");
        step(0, 0, 0, 0, 0, 0, '0, "R2 idle");
        @(negedge clk);
        check_resp();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule